// File: doc/BRIEF.md
# Zoomed-Video Socket Control Register Block

This block holds the control state for the zoomed-video port of a two-socket card controller. Software reaches it over a simple synchronous 32-bit read/write bus with byte enables. Each socket has its own memory-mapped window. Each window holds a present-state register, a force-event register and a socket control register. A shared configuration dword carries a legacy card-control byte and a diagnostic byte. The block drives one zoomed-video enable line per socket.

Each socket has a platform-support flag. Software cannot write this flag in the present-state register. It can only be loaded through the force-event register, which always reads back as zero. A socket's effective enable is the legacy enable OR'd with that socket's own enable bit. The socket's own enable counts only while the diagnostic disable bit is clear. The legacy enable applies to both sockets and stays usable whatever the diagnostic bit says.

The socket control register also reports two read-only flags. The capability flag reads 1 while the standardized model is in effect. The activity flag reads 1 when either socket's output is enabled.

Writes take effect on the clock edge at which `bus_wr` is sampled high. Reads are combinational from the address.

Top module: `zv_socket_ctrl`

## Requirements
- R1: After reset, both enable outputs are 0. Each socket control register reads 32'h0000_0400, and the configuration dword and both present-state registers read 0.
- R2: A write to a present-state register (socket offset 08h) changes nothing. Its bit 27 keeps its previous value.
- R3: A write to the force-event register (socket offset 0Ch) with byte enable 3 set loads bit 27 of the data into that socket's support flag, so writing 0 clears it. Without byte enable 3 the flag is unchanged. The flag reads at bit 27 of offset 08h.
- R4: The force-event register always reads 0.
- R5: A write to socket control (offset 10h) with byte enable 1 set loads data bit 9 into that socket's enable. Without byte enable 1 the stored enable is unchanged. Bit 9 reads back the stored value.
- R6: Socket control bit 10 reads 1 exactly when the diagnostic disable bit is 0.
- R7: Socket control bit 11 reads 1 in both sockets when either enable output is 1.
- R8: The diagnostic disable bit is configuration dword 90h bit 24 (offset 93h bit 0, byte enable 3). While it is 1, the socket-control enables do not reach the outputs.
- R9: The legacy enable is configuration dword 90h bit 14 (offset 91h bit 6, byte enable 1). While it is 1, both outputs are 1 regardless of the diagnostic bit.
- R10: Reserved bits, unmapped offsets and non-dword-aligned addresses read 0.
- R11: Sockets are independent. The window with address bit 7 = 1 is socket 1 and only touches socket 1 state, apart from the shared activity flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cfg | input | 1 | 1 selects configuration space, 0 the socket windows |
| bus_addr | input | 8 | Byte address; in socket space bit 7 picks the socket |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| zv_en_o | output | 2 | Effective zoomed-video enable per socket |

## Verification
The bench writs 1s to every bit of the read-only present-state register. A design that let bit 27 through would report platform support that was never forced. It checks that the force-event register reads 0 even after being loaded, and that writing 0 with byte enable 3 clears the flag, so a design that only ever sets the flag is caught. It sets the diagnostic bit while a socket enable is stored and expects the output to drop while bit 9 still reads 1; a design that cleared the stored bit, or ignored the diagnostic bit, fails here. It then turns on the legacy bit with the diagnostic bit still set and expects both outputs to go high. It also checks that socket 1 reports activity caused by socket 0 alone and that writes lacking the right byte enable leave state untouched.

// File: rtl/zv_pkg.sv
package zv_pkg;
    localparam int NUM_SOCK    = 2;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int BE_W        = DATA_W / 8;

    localparam logic [6:0] OFF_PRESENT = 7'h08;
    localparam logic [6:0] OFF_FORCE   = 7'h0C;
    localparam logic [6:0] OFF_CTRL    = 7'h10;
    localparam logic [ADDR_W-1:0] CFG_DWORD = 8'h90;

    localparam int BIT_SUPPORT = 27;
    localparam int BIT_SOCK_EN = 9;
    localparam int BIT_CAP     = 10;
    localparam int BIT_ACTIVE  = 11;
    localparam int BIT_LEGACY  = 14;
    localparam int BIT_DIAG    = 24;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRESENT,
        SEL_FORCE,
        SEL_CTRL,
        SEL_CFG
    } zv_sel_e;
endpackage

// File: rtl/zv_addr_decode.sv
module zv_addr_decode
    import zv_pkg::*;
(
    input  logic              cfg_space,
    input  logic [ADDR_W-1:0] addr,
    output zv_sel_e           sel,
    output logic              sock
);
    always_comb begin
        sel  = SEL_NONE;
        sock = addr[ADDR_W-1];
        if (cfg_space) begin
            if (addr == CFG_DWORD) sel = SEL_CFG;
        end else begin
            unique case (addr[6:0])
                OFF_PRESENT: sel = SEL_PRESENT;
                OFF_FORCE:   sel = SEL_FORCE;
                OFF_CTRL:    sel = SEL_CTRL;
                default:     sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/zv_sock_regs.sv
module zv_sock_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic force_wr,
    input  logic force_val,
    input  logic ctrl_wr,
    input  logic ctrl_val,
    output logic support_q,
    output logic enable_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            support_q <= 1'b0;
            enable_q  <= 1'b0;
        end else begin
            if (force_wr) support_q <= force_val;
            if (ctrl_wr)  enable_q  <= ctrl_val;
        end
    end
endmodule

// File: rtl/zv_cfg_regs.sv
module zv_cfg_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic legacy_wr,
    input  logic legacy_val,
    input  logic diag_wr,
    input  logic diag_val,
    output logic legacy_q,
    output logic diag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_q <= 1'b0;
            diag_q   <= 1'b0;
        end else begin
            if (legacy_wr) legacy_q <= legacy_val;
            if (diag_wr)   diag_q   <= diag_val;
        end
    end
endmodule

// File: rtl/zv_socket_ctrl.sv
module zv_socket_ctrl
    import zv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_SOCK-1:0] zv_en_o
);
    zv_sel_e sel;
    logic    sock;
    logic [NUM_SOCK-1:0] sup_q;
    logic [NUM_SOCK-1:0] sen_q;
    logic legacy_q;
    logic diag_q;

    zv_addr_decode u_dec (
        .cfg_space (bus_cfg),
        .addr      (bus_addr),
        .sel       (sel),
        .sock      (sock)
    );

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        logic hit;
        assign hit = bus_wr && (sock == s[0]);
        zv_sock_regs u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_wr  (hit && sel == SEL_FORCE && bus_be[BIT_SUPPORT/8]),
            .force_val (bus_wdata[BIT_SUPPORT]),
            .ctrl_wr   (hit && sel == SEL_CTRL && bus_be[BIT_SOCK_EN/8]),
            .ctrl_val  (bus_wdata[BIT_SOCK_EN]),
            .support_q (sup_q[s]),
            .enable_q  (sen_q[s])
        );
        assign zv_en_o[s] = legacy_q | (sen_q[s] & ~diag_q);
    end

    zv_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .legacy_wr  (bus_wr && sel == SEL_CFG && bus_be[BIT_LEGACY/8]),
        .legacy_val (bus_wdata[BIT_LEGACY]),
        .diag_wr    (bus_wr && sel == SEL_CFG && bus_be[BIT_DIAG/8]),
        .diag_val   (bus_wdata[BIT_DIAG]),
        .legacy_q   (legacy_q),
        .diag_q     (diag_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_PRESENT: bus_rdata[BIT_SUPPORT] = sup_q[sock];
            SEL_CTRL: begin
                bus_rdata[BIT_SOCK_EN] = sen_q[sock];
                bus_rdata[BIT_CAP]     = ~diag_q;
                bus_rdata[BIT_ACTIVE]  = |zv_en_o;
            end
            SEL_CFG: begin
                bus_rdata[BIT_LEGACY] = legacy_q;
                bus_rdata[BIT_DIAG]   = diag_q;
            end
            SEL_FORCE, SEL_NONE: bus_rdata = '0;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/zv_socket_ctrl_checker.sv
module zv_socket_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_cfg,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic [3:0]  bus_be,
    input logic [31:0] bus_rdata,
    input logic [1:0]  zv_en_o,
    input logic [1:0]  sup_q,
    input logic        legacy_q,
    input logic        diag_q
);
    logic rd_ctrl, rd_force, wr_ps, wr_fe3;
    assign rd_ctrl  = !bus_cfg && bus_addr[6:0] == 7'h10;
    assign rd_force = !bus_cfg && bus_addr[6:0] == 7'h0C;
    assign wr_ps    = bus_wr && !bus_cfg && bus_addr[6:0] == 7'h08;
    assign wr_fe3   = bus_wr && !bus_cfg && bus_addr[6:0] == 7'h0C && bus_be[3];

    // R2
    a_r2_present_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ps && !wr_fe3) |=> (sup_q == $past(sup_q)));
    // R4
    a_r4_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_force |-> (bus_rdata == 32'h0));
    // R6
    a_r6_cap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |-> (bus_rdata[10] == !diag_q));
    // R7
    a_r7_activity: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |-> (bus_rdata[11] == (|zv_en_o)));
    // R8
    a_r8_diag_masks: assert property (@(posedge clk) disable iff (!rst_n)
        diag_q |-> (zv_en_o == {2{legacy_q}}));
    // R9
    a_r9_legacy_both: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_q |-> (zv_en_o == 2'b11));
endmodule

bind zv_socket_ctrl zv_socket_ctrl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cfg   (bus_cfg),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .zv_en_o   (zv_en_o),
    .sup_q     (sup_q),
    .legacy_q  (legacy_q),
    .diag_q    (diag_q)
);

// File: tb/zv_socket_ctrl_test.sv
module zv_socket_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cfg = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  zv_en_o;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    zv_socket_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_cfg(bus_cfg), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .zv_en_o(zv_en_o)
    );

    // {req, cfg, addr, wr, be, data (wdata or expected rdata), expected zv}
    localparam int NV = 26;
    localparam logic [51:0] VEC [NV] = '{
        {4'd1, 1'b0,8'h10,1'b0,4'h0,32'h0000_0400,2'b00}, // R1 s0 ctrl
        {4'd1, 1'b0,8'h90,1'b0,4'h0,32'h0000_0400,2'b00}, // R1 s1 ctrl
        {4'd5, 1'b0,8'h10,1'b1,4'h2,32'h0000_0200,2'b01}, // R5 enable s0
        {4'd7, 1'b0,8'h10,1'b0,4'h0,32'h0000_0E00,2'b01}, // R7
        {4'd11,1'b0,8'h90,1'b0,4'h0,32'h0000_0C00,2'b01}, // R11 R7 shared activity
        {4'd2, 1'b0,8'h08,1'b1,4'hF,32'hFFFF_FFFF,2'b01}, // R2 write ps
        {4'd2, 1'b0,8'h08,1'b0,4'h0,32'h0000_0000,2'b01}, // R2 unchanged
        {4'd3, 1'b0,8'h0C,1'b1,4'h8,32'h0800_0000,2'b01}, // R3 force set
        {4'd3, 1'b0,8'h08,1'b0,4'h0,32'h0800_0000,2'b01}, // R3
        {4'd4, 1'b0,8'h0C,1'b0,4'h0,32'h0000_0000,2'b01}, // R4
        {4'd11,1'b0,8'h88,1'b0,4'h0,32'h0000_0000,2'b01}, // R11 s1 ps
        {4'd8, 1'b1,8'h90,1'b1,4'h8,32'h0100_0000,2'b00}, // R8 diag on
        {4'd6, 1'b0,8'h10,1'b0,4'h0,32'h0000_0200,2'b00}, // R6 R8
        {4'd9, 1'b1,8'h90,1'b1,4'h2,32'h0000_4000,2'b11}, // R9 legacy on
        {4'd9, 1'b1,8'h90,1'b0,4'h0,32'h0100_4000,2'b11}, // R9 R10 cfg read
        {4'd7, 1'b0,8'h90,1'b0,4'h0,32'h0000_0800,2'b11}, // R7
        {4'd9, 1'b1,8'h90,1'b1,4'h2,32'h0000_0000,2'b00}, // R9 legacy off
        {4'd8, 1'b1,8'h90,1'b1,4'h8,32'h0000_0000,2'b01}, // R8 diag off
        {4'd3, 1'b0,8'h0C,1'b1,4'h7,32'h0000_0000,2'b01}, // R3 no be3
        {4'd3, 1'b0,8'h08,1'b0,4'h0,32'h0800_0000,2'b01}, // R3 kept
        {4'd3, 1'b0,8'h0C,1'b1,4'h8,32'h0000_0000,2'b01}, // R3 clear
        {4'd3, 1'b0,8'h08,1'b0,4'h0,32'h0000_0000,2'b01}, // R3 cleared
        {4'd5, 1'b0,8'h10,1'b1,4'h1,32'h0000_0000,2'b01}, // R5 no be1
        {4'd10,1'b0,8'h11,1'b0,4'h0,32'h0000_0000,2'b01}, // R10 unaligned
        {4'd11,1'b0,8'h90,1'b1,4'h2,32'hFFFF_FFFF,2'b11}, // R11 enable s1
        {4'd10,1'b0,8'h90,1'b0,4'h0,32'h0000_0E00,2'b11}  // R10 reserved zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [51:0] v);
        string tag;
        tag = $sformatf("R%0d", v[51:48]);
        @(negedge clk);
        bus_cfg = v[47]; bus_addr = v[46:39]; bus_wr = v[38];
        bus_be = v[37:34]; bus_wdata = v[33:2];
        if (v[38]) begin
            @(posedge clk);
            @(negedge clk);
            bus_wr = 1'b0; bus_be = '0;
        end else begin
            #1 check(tag, bus_rdata, v[33:2]);
        end
        check(tag, {30'd0, zv_en_o}, {30'd0, v[1:0]});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(VEC[i]);
        // R1: reset mid-run clears all state
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", {30'd0, zv_en_o}, 32'h0);
        bus_cfg = 1'b0; bus_addr = 8'h90; #1 check("R1", bus_rdata, 32'h0000_0400);
        bus_addr = 8'h08; #1 check("R1", bus_rdata, 32'h0);
        bus_cfg = 1'b1; bus_addr = 8'h90; #1 check("R1", bus_rdata, 32'h0);
        rst_n = 1'b1;
        // R11: socket 1 force write leaves socket 0 flag clear
        apply({4'd11,1'b0,8'h8C,1'b1,4'h8,32'h0800_0000,2'b00});
        apply({4'd11,1'b0,8'h08,1'b0,4'h0,32'h0000_0000,2'b00});
        apply({4'd11,1'b0,8'h88,1'b0,4'h0,32'h0800_0000,2'b00});
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule